// File: doc/BRIEF.md
# External NMI trigger conditioner

This block turns one asynchronous external non-maskable interrupt pad into a clean, latched, active-high request for a parent interrupt controller. The pad first passes through a synchroniser. A detector then looks for the event that the programmed trigger type selects: a low level, a high level, a falling edge or a rising edge. Each detected event sets a request latch. The latch drives the request output, so the parent controller always sees an active-high level, whatever trigger type is in use.

Software programs the trigger type and clears the latch through a small register port. The port has a write strobe, an address, the two implemented write-data bits and a registered read-data word. Writing 1 to bit 0 of the pending register clears the latch. The same bit reads back the latch state.

Top module: `nmi_cond_latch`

## Requirements
- R1: After a synchronous reset, `irq_o` and `pend_o` are 0, the trigger type is level low (0) and the control register reads back 0. The synchroniser resets to the pad-high idle value.
- R2: The trigger type is bits [1:0] of the control register at byte address 0x0C. The encoding is 0 = level low, 1 = falling edge, 2 = level high, 3 = rising edge. The field reads back in bits [1:0] with all other bits 0.
- R3: A pad change reaches `irq_o` on the third rising clock edge after the change. The first two edges are the synchroniser stages and the third is the latch. The output is still unchanged after the second edge.
- R4: In the level modes (0, 2), the latch sets while the synchronised pad sits at the selected level (0 for mode 0, 1 for mode 2). It does not set while the pad sits at the other level.
- R5: In the edge modes (1, 3), only a transition in the selected direction sets the latch. A steady pad or a transition in the opposite direction leaves it unchanged.
- R6: A write to the pending register (address 0x10) with write-data bit 0 = 1 clears the latch on that clock edge. A write with bit 0 = 0 has no effect, whatever the other bits hold.
- R7: In a level mode, a clear issued while the pad is still active leaves the latch set.
- R8: When a detected event and a clear fall on the same clock edge, the latch ends up set.
- R9: Any write to the control register suppresses edge detection for the next cycle, so that changing the trigger type produces no false edge.
- R10: `irq_o` is an active-high copy of the latch in every mode. `pend_o` equals the latch. Reading address 0x10 returns the latch in bit 0, one clock after the address is presented.
- R11: Writes to addresses other than 0x0C and 0x10 change nothing, and reads of them return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pad_i | input | 1 | Asynchronous NMI pad |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W (8) | Register byte address |
| reg_wdata | input | 2 | Implemented write-data bits |
| reg_rdata | output | DATA_W (32) | Registered read data for `reg_addr` |
| irq_o | output | 1 | Active-high latched request to the parent controller |
| pend_o | output | 1 | Pending status (latch state) |

## Verification
A pad change is due at the outputs on the third edge after it is driven. A clear or a control write takes effect on the edge that samples it. Read data appears one edge after the address is presented. The bench drives every input on the falling edge and counts falling edges to sample at those points. For each of the four trigger types it also checks that the output is still low after only two edges. The same-edge collision of a clear and an edge event is produced by issuing the clear exactly two falling edges after the pad change.

// File: rtl/nmi_cond_pkg.sv
package nmi_cond_pkg;
  // bit 0: edge-sensitive, bit 1: active-high
  typedef enum logic [1:0] {
    TRIG_LVL_LO    = 2'd0,
    TRIG_EDGE_FALL = 2'd1,
    TRIG_LVL_HI    = 2'd2,
    TRIG_EDGE_RISE = 2'd3
  } trig_mode_e;

  localparam int MODE_W = 2;
endpackage

// File: rtl/nmi_pad_sync.sv
module nmi_pad_sync #(
  parameter int   STAGES = 2,
  parameter logic IDLE   = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic pad_i,
  output logic sync_o
);
  logic [STAGES-1:0] shreg_q;

  always_ff @(posedge clk) begin
    if (rst) shreg_q <= {STAGES{IDLE}};
    else     shreg_q <= {shreg_q[STAGES-2:0], pad_i};
  end

  assign sync_o = shreg_q[STAGES-1];
endmodule

// File: rtl/nmi_trig_detect.sv
module nmi_trig_detect
  import nmi_cond_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       sync_i,
  input  trig_mode_e mode_i,
  input  logic       mode_wr_i,
  output logic       event_o
);
  logic act_lvl;
  logic hist_q;

  // Fold polarity so that 1 always means "active".
  always_comb begin
    act_lvl = sync_i ^ ~mode_i[1];
    if (mode_i[0]) event_o = act_lvl & ~hist_q;
    else           event_o = act_lvl;
  end

  // History is forced to "active" on reset and on any mode write,
  // masking a polarity flip that would otherwise look like an edge.
  always_ff @(posedge clk) begin
    if (rst)            hist_q <= 1'b1;
    else if (mode_wr_i) hist_q <= 1'b1;
    else                hist_q <= act_lvl;
  end
endmodule

// File: rtl/nmi_req_latch.sv
module nmi_req_latch (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk) begin
    if (rst)        q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end
endmodule

// File: rtl/nmi_cond_latch.sv
module nmi_cond_latch
  import nmi_cond_pkg::*;
#(
  parameter int              ADDR_W      = 8,
  parameter int              DATA_W      = 32,
  parameter int              SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h0C,
  parameter logic [ADDR_W-1:0] PEND_ADDR = 8'h10,
  parameter trig_mode_e      RST_MODE    = TRIG_LVL_LO
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 pad_i,
  input  logic                 reg_wr,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [MODE_W-1:0]    reg_wdata,
  output logic [DATA_W-1:0]    reg_rdata,
  output logic                 irq_o,
  output logic                 pend_o
);
  localparam int PAD_W = DATA_W - MODE_W;

  trig_mode_e mode_q;
  logic       pad_sync;
  logic       det_event;
  logic       latch_q;
  logic       ctrl_wr;
  logic       pend_clr;

  assign ctrl_wr  = reg_wr && (reg_addr == CTRL_ADDR);
  assign pend_clr = reg_wr && (reg_addr == PEND_ADDR) && reg_wdata[0];

  always_ff @(posedge clk) begin
    if (rst)          mode_q <= RST_MODE;
    else if (ctrl_wr) mode_q <= trig_mode_e'(reg_wdata);
  end

  nmi_pad_sync #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) sync_i (
    .clk(clk), .rst(rst), .pad_i(pad_i), .sync_o(pad_sync)
  );

  nmi_trig_detect det_i (
    .clk(clk), .rst(rst), .sync_i(pad_sync), .mode_i(mode_q),
    .mode_wr_i(ctrl_wr), .event_o(det_event)
  );

  nmi_req_latch latch_i (
    .clk(clk), .rst(rst), .set_i(det_event), .clr_i(pend_clr), .q_o(latch_q)
  );

  always_ff @(posedge clk) begin
    if (rst)                        reg_rdata <= '0;
    else if (reg_addr == CTRL_ADDR) reg_rdata <= {{PAD_W{1'b0}}, mode_q};
    else if (reg_addr == PEND_ADDR) reg_rdata <= {{(DATA_W-1){1'b0}}, latch_q};
    else                            reg_rdata <= '0;
  end

  assign irq_o  = latch_q;
  assign pend_o = latch_q;
endmodule

// File: rtl/nmi_cond_latch_chk.sv
module nmi_cond_latch_chk
  import nmi_cond_pkg::*;
#(
  parameter int                ADDR_W    = 8,
  parameter int                DATA_W    = 32,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h0C,
  parameter logic [ADDR_W-1:0] PEND_ADDR = 8'h10
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [MODE_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              det_event,
  input logic              latch_q,
  input trig_mode_e        mode_q
);
  // R8
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    det_event |=> latch_q);

  // R6
  w1c_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == PEND_ADDR && reg_wdata[0] && !det_event) |=> !latch_q);

  // R6
  fall_needs_clr_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(latch_q) |-> $past(reg_wr && reg_addr == PEND_ADDR && reg_wdata[0]));

  // R4
  rise_needs_event_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(latch_q) |-> $past(det_event));

  // R9
  no_false_edge_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == CTRL_ADDR && reg_wdata[0]) |=> !det_event);

  // R2
  ctrl_readback_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_addr == CTRL_ADDR) |=> (reg_rdata == {{(DATA_W-MODE_W){1'b0}}, $past(mode_q)}));
endmodule

bind nmi_cond_latch nmi_cond_latch_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR), .PEND_ADDR(PEND_ADDR)
) chk_i (.*);

// File: tb/nmi_cond_latch_tb_top.sv
module nmi_cond_latch_tb_top;
  localparam logic [7:0] CTRL = 8'h0C;
  localparam logic [7:0] PEND = 8'h10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pad_i = 1'b1;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = 8'h00;
  logic [1:0]  reg_wdata = 2'b00;
  logic [31:0] reg_rdata;
  logic        irq_o, pend_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  nmi_cond_latch dut_i (
    .clk(clk), .rst(rst), .pad_i(pad_i), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o), .pend_o(pend_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [1:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = 2'b00;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  initial begin
    logic [31:0] rv;
    tick(3);
    rst = 1'b0;
    tick(4);
    check("R1 irq after reset", 32'(irq_o), 0);
    check("R1 pend after reset", 32'(pend_o), 0);
    rd(CTRL, rv);
    check("R1 mode after reset", rv, 0);

    for (int mi = 0; mi < 4; mi++) begin
      logic [1:0] m;
      logic act, is_edge;
      m = 2'(mi);
      act = m[1];
      is_edge = m[0];
      pad_i = ~act;
      wr(CTRL, m);
      tick(4);
      wr(PEND, 2'b01);
      check("R6 clear idle", 32'(irq_o), 0);
      rd(CTRL, rv);
      check("R2 mode readback", rv, 32'(m));

      pad_i = act;
      tick(2);
      check("R3 not yet after two edges", 32'(irq_o), 0);
      tick(1);
      check(is_edge ? "R5 selected edge sets" : "R4 active level sets", 32'(irq_o), 1);
      check("R10 pend_o follows latch", 32'(pend_o), 1);
      rd(PEND, rv);
      check("R10 pending readback", rv, 1);

      wr(PEND, 2'b00);
      check("R6 write zero ignored", 32'(irq_o), 1);
      wr(PEND, 2'b10);
      check("R6 other bit ignored", 32'(irq_o), 1);

      wr(PEND, 2'b01);
      check(is_edge ? "R6 clear in edge mode" : "R7 level still active", 32'(irq_o),
            is_edge ? 0 : 1);

      pad_i = ~act;
      tick(4);
      check(is_edge ? "R5 opposite edge ignored" : "R4 level held", 32'(irq_o),
            is_edge ? 0 : 1);
      wr(PEND, 2'b01);
      check("R4 inactive level stays clear", 32'(irq_o), 0);

      if (is_edge) begin
        pad_i = act;
        tick(2);
        wr(PEND, 2'b01);
        check("R8 set wins over clear", 32'(irq_o), 1);
        pad_i = ~act;
        tick(4);
        wr(PEND, 2'b01);
        check("R8 cleared afterwards", 32'(irq_o), 0);
      end
    end

    // R9: rising mode, pad low, switch to falling
    wr(CTRL, 2'd3);
    pad_i = 1'b0;
    tick(4);
    wr(PEND, 2'b01);
    check("R9 setup clear", 32'(irq_o), 0);
    wr(CTRL, 2'd1);
    tick(4);
    check("R9 no false edge on mode change", 32'(irq_o), 0);
    pad_i = 1'b1;
    tick(4);
    pad_i = 1'b0;
    tick(3);
    check("R9 real falling edge after change", 32'(irq_o), 1);
    wr(PEND, 2'b01);

    wr(8'h20, 2'd3);
    rd(CTRL, rv);
    check("R11 unmapped write ignored", rv, 1);
    rd(8'h20, rv);
    check("R11 unmapped read zero", rv, 0);
    check("R11 latch untouched", 32'(irq_o), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule